// File: doc/BRIEF.md
# Three-Operand Floating-Point Adder

This block adds three single-precision floating-point numbers in a single pass and returns one single-precision sum. Each word has 1 sign bit, 8 exponent bits and 23 fraction bits, in the usual IEEE-754 order: sign in bit 31, exponent in bits 30:23 and fraction in bits 22:0. The block sums all three operands together instead of chaining two-operand adders. It therefore needs only one exponent alignment and one normalization for each result.

The pipeline has two parts. The front end restores the hidden leading one of each operand and finds the largest exponent among the nonzero operands. It then shifts every mantissa right by its distance from that exponent. The shifter reverses the bit order, multiplies by a power of two and reverses the bits back. The back end converts each aligned mantissa to two's complement using its sign and adds the three. It then finds the leading one of the sum's magnitude and shifts it into the hidden-bit position. The exponent is adjusted to match, and the bits below the fraction are dropped (truncation). A new operand set can enter on every clock. Each result appears a fixed six cycles later.

Top module: `fp3_adder`

## Requirements
- R1: The result is a 32-bit word with the sign in bit 31, the biased exponent in bits 30:23 and the fraction in bits 22:0. The sum of 1.0, 2.0 and 3.0 is 0x40C00000.
- R2: `out_valid` equals `in_valid` delayed by exactly 6 clock cycles. Operand sets on consecutive cycles each produce their own result 6 cycles later. After reset, `out_valid` and `result` are 0.
- R3: An operand whose exponent field is 0 counts as zero, whatever its sign and fraction bits. It adds nothing to the sum and plays no part in choosing the common exponent.
- R4: The common exponent is the largest exponent among the nonzero operands. Each nonzero operand's mantissa, with its hidden 1 restored, is shifted right by the difference between the common exponent and its own exponent. Bits shifted out below the 24-bit mantissa are lost.
- R5: An operand whose exponent is 24 or more below the common exponent adds nothing to the sum.
- R6: An operand with its sign bit set is subtracted. The result's sign bit is 1 exactly when the signed sum is negative.
- R7: The sum is normalized. A carry out shifts the mantissa right and raises the exponent. Cancellation shifts it left and lowers the exponent. Fraction bits below bit 0 are truncated, for example 3 × 0x3F800001 gives 0x40400001.
- R8: When the signed sum is exactly zero, the result is 0x00000000, whatever the operand signs.
- R9: When the normalized exponent would be below 1, the result is 0x00000000. A normalized exponent of exactly 1 is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks the three operand words as a set to add |
| op_a | input | 32 | First operand, single precision |
| op_b | input | 32 | Second operand, single precision |
| op_c | input | 32 | Third operand, single precision |
| out_valid | output | 1 | Marks `result` as holding a sum |
| result | output | 32 | Truncated single-precision sum of the three operands |

## Verification
The assertions assume that `in_valid` is a known value on every clock after reset, and that no operand is a NaN, an infinity or a denormal. Under that assumption, an all-zero exponent field means zero. They also assume that no sum carries the exponent past 254. The bench keeps ordinary operands at biased exponents between 100 and 157, where two bits of carry cannot overflow. It uses exponents 1 and 2 only in the scenario that aims at the flush-to-zero boundary. Bit patterns with a zero exponent and a nonzero fraction appear only as stimulus for the rule that treats them as zero.

// File: rtl/fp3_pkg.sv
package fp3_pkg;

    localparam int EXP_W        = 8;
    localparam int FRAC_W       = 23;
    localparam int WORD_W       = 1 + EXP_W + FRAC_W;
    localparam int MANT_W       = FRAC_W + 1;
    localparam int NUM_OPS      = 3;
    localparam int GUARD_W      = $clog2(NUM_OPS);
    localparam int MAG_W        = MANT_W + GUARD_W;
    localparam int SUM_W        = MAG_W + 1;
    localparam int POS_W        = $clog2(MAG_W);
    localparam int ALIGN_STAGES = 4;
    localparam int NORM_STAGES  = 2;
    localparam int LATENCY      = ALIGN_STAGES + NORM_STAGES;

    typedef logic [EXP_W-1:0]  exp_t;
    typedef logic [MANT_W-1:0] mant_t;

    typedef struct packed {
        logic  sign;
        logic  zero;
        exp_t  exp;
        mant_t mant;
    } op_t;

    typedef struct packed {
        logic  sign;
        mant_t mag;
    } aligned_t;

    // Split a word into fields, restore the hidden one, flag zero by exponent.
    function automatic op_t unpack_word(input logic [WORD_W-1:0] w);
        op_t o;
        o.sign = w[WORD_W-1];
        o.exp  = w[WORD_W-2 -: EXP_W];
        o.zero = (o.exp == '0);
        o.mant = o.zero ? '0 : {1'b1, w[FRAC_W-1:0]};
        return o;
    endfunction

    // Index of the highest set bit (0 when none is set).
    function automatic logic [POS_W-1:0] lead_one(input logic [MAG_W-1:0] m);
        logic [POS_W-1:0] p;
        p = '0;
        for (int i = 0; i < MAG_W; i++) begin
            if (m[i]) p = POS_W'(i);
        end
        return p;
    endfunction

endpackage

// File: rtl/fp3_revshift.sv
// Right shift built as: reverse bits, multiply by 2^sh, reverse back.
module fp3_revshift #(
    parameter int W    = 24,
    parameter int SH_W = 8
) (
    input  logic [W-1:0]    din,
    input  logic [SH_W-1:0] sh,
    output logic [W-1:0]    dout
);

    logic [W-1:0] rev_in;
    logic [W-1:0] pow;
    logic [W-1:0] prod_lo;
    logic         in_range;

    generate
        for (genvar i = 0; i < W; i++) begin : g_rev_in
            assign rev_in[i] = din[W-1-i];
        end
    endgenerate

    assign in_range = (sh < SH_W'(W));
    assign pow      = in_range ? (W'(1) << sh) : '0;
    assign prod_lo  = rev_in * pow;

    generate
        for (genvar i = 0; i < W; i++) begin : g_rev_out
            assign dout[i] = prod_lo[W-1-i];
        end
    endgenerate

endmodule

// File: rtl/fp3_align.sv
// Exponent front end: unpack, max exponent, distances, shifted mantissas.
module fp3_align
    import fp3_pkg::*;
#(
    parameter int N = NUM_OPS
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic [N-1:0][WORD_W-1:0]   words,
    output logic                       out_valid,
    output exp_t                       out_emax,
    output aligned_t [N-1:0]           out_ops
);

    // stage 1: unpacked operands
    op_t [N-1:0]  s1_ops;
    logic         s1_v;
    // stage 2: operands with the common exponent
    op_t [N-1:0]  s2_ops;
    exp_t         s2_emax;
    logic         s2_v;
    exp_t         emax_c;
    // stage 3: shift distances
    exp_t  [N-1:0] s3_sh;
    logic  [N-1:0] s3_sign;
    logic  [N-1:0] s3_zero;
    mant_t [N-1:0] s3_mant;
    exp_t          s3_emax;
    logic          s3_v;
    mant_t [N-1:0] shifted;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_v   <= 1'b0;
            s1_ops <= '0;
        end else begin
            s1_v <= in_valid;
            for (int i = 0; i < N; i++) begin
                s1_ops[i] <= unpack_word(words[i]);
            end
        end
    end

    always_comb begin
        emax_c = '0;
        for (int i = 0; i < N; i++) begin
            if (!s1_ops[i].zero && (s1_ops[i].exp > emax_c)) emax_c = s1_ops[i].exp;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_v    <= 1'b0;
            s2_ops  <= '0;
            s2_emax <= '0;
        end else begin
            s2_v    <= s1_v;
            s2_ops  <= s1_ops;
            s2_emax <= emax_c;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s3_v    <= 1'b0;
            s3_sh   <= '0;
            s3_sign <= '0;
            s3_zero <= '0;
            s3_mant <= '0;
            s3_emax <= '0;
        end else begin
            s3_v    <= s2_v;
            s3_emax <= s2_emax;
            for (int i = 0; i < N; i++) begin
                s3_sh[i]   <= s2_emax - s2_ops[i].exp;
                s3_sign[i] <= s2_ops[i].sign;
                s3_zero[i] <= s2_ops[i].zero;
                s3_mant[i] <= s2_ops[i].mant;
            end
        end
    end

    generate
        for (genvar g = 0; g < N; g++) begin : g_shift
            fp3_revshift #(
                .W    (MANT_W),
                .SH_W (EXP_W)
            ) u_shift (
                .din  (s3_mant[g]),
                .sh   (s3_sh[g]),
                .dout (shifted[g])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_emax  <= '0;
            out_ops   <= '0;
        end else begin
            out_valid <= s3_v;
            out_emax  <= s3_emax;
            for (int i = 0; i < N; i++) begin
                out_ops[i].sign <= s3_sign[i];
                out_ops[i].mag  <= s3_zero[i] ? '0 : shifted[i];
            end
        end
    end

    generate
        for (genvar g = 0; g < N; g++) begin : g_chk
            // R4: no nonzero operand sits above the chosen exponent
            p_emax_cover_r4: assert property (@(posedge clk) disable iff (rst)
                s2_v && !s2_ops[g].zero |-> s2_emax >= s2_ops[g].exp);
            // R5: a distance of a full mantissa or more leaves nothing
            p_far_drop_r5: assert property (@(posedge clk) disable iff (rst)
                s3_v && (s3_sh[g] >= EXP_W'(MANT_W)) |=> out_ops[g].mag == '0);
            // R3: a zero operand leaves nothing
            p_zero_drop_r3: assert property (@(posedge clk) disable iff (rst)
                s3_v && s3_zero[g] |=> out_ops[g].mag == '0);
        end
    endgenerate

endmodule

// File: rtl/fp3_mant_norm.sv
// Mantissa back end: signed sum, then leading-one normalization with truncation.
module fp3_mant_norm
    import fp3_pkg::*;
#(
    parameter int N = NUM_OPS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  exp_t                in_emax,
    input  aligned_t [N-1:0]    in_ops,
    output logic                out_valid,
    output logic [WORD_W-1:0]   result
);

    localparam int EXT_W = EXP_W + 3;

    logic signed [SUM_W-1:0] sum_c;
    logic signed [SUM_W-1:0] s5_sum;
    exp_t                    s5_emax;
    logic                    s5_v;

    logic                    neg_c;
    logic [MAG_W-1:0]        mag_c;
    logic [POS_W-1:0]        lead_c;
    logic signed [EXT_W-1:0] exp_c;
    logic [FRAC_W-1:0]       frac_c;
    logic                    zero_c;
    logic [WORD_W-1:0]       word_c;

    always_comb begin
        sum_c = '0;
        for (int i = 0; i < N; i++) begin
            if (in_ops[i].sign)
                sum_c = sum_c - $signed({{(SUM_W-MANT_W){1'b0}}, in_ops[i].mag});
            else
                sum_c = sum_c + $signed({{(SUM_W-MANT_W){1'b0}}, in_ops[i].mag});
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s5_v    <= 1'b0;
            s5_sum  <= '0;
            s5_emax <= '0;
        end else begin
            s5_v    <= in_valid;
            s5_sum  <= sum_c;
            s5_emax <= in_emax;
        end
    end

    always_comb begin
        neg_c  = s5_sum[SUM_W-1];
        mag_c  = neg_c ? MAG_W'(-s5_sum) : MAG_W'(s5_sum);
        lead_c = lead_one(mag_c);
        exp_c  = $signed({3'b000, s5_emax})
               + $signed({{(EXT_W-POS_W){1'b0}}, lead_c})
               - $signed(EXT_W'(FRAC_W));
        if (lead_c >= POS_W'(FRAC_W))
            frac_c = FRAC_W'(mag_c >> (lead_c - POS_W'(FRAC_W)));
        else
            frac_c = FRAC_W'(mag_c << (POS_W'(FRAC_W) - lead_c));
        zero_c = (mag_c == '0) || (exp_c < $signed(EXT_W'(1)));
        word_c = zero_c ? '0 : {neg_c, exp_c[EXP_W-1:0], frac_c};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= s5_v;
            result    <= word_c;
        end
    end

    // R8: a zero exponent field only ever leaves as the all-zero word
    p_zero_word_r8: assert property (@(posedge clk) disable iff (rst)
        out_valid && (result[WORD_W-2 -: EXP_W] == '0) |-> result == '0);
    // R6: a negative sum yields a set sign bit unless flushed to zero
    p_neg_sign_r6: assert property (@(posedge clk) disable iff (rst)
        s5_v && s5_sum[SUM_W-1] |=> result[WORD_W-1] || (result == '0));
    // R6: a positive sum never yields a set sign bit
    p_pos_sign_r6: assert property (@(posedge clk) disable iff (rst)
        s5_v && !s5_sum[SUM_W-1] |=> !result[WORD_W-1]);

endmodule

// File: rtl/fp3_adder.sv
module fp3_adder
    import fp3_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic [WORD_W-1:0] op_c,
    output logic              out_valid,
    output logic [WORD_W-1:0] result
);

    localparam int CNT_W = $clog2(LATENCY + 1);

    logic [NUM_OPS-1:0][WORD_W-1:0] words;
    logic                           al_valid;
    exp_t                           al_emax;
    aligned_t [NUM_OPS-1:0]         al_ops;

    assign words = {op_c, op_b, op_a};

    fp3_align #(
        .N (NUM_OPS)
    ) u_align (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .words     (words),
        .out_valid (al_valid),
        .out_emax  (al_emax),
        .out_ops   (al_ops)
    );

    fp3_mant_norm #(
        .N (NUM_OPS)
    ) u_norm (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (al_valid),
        .in_emax   (al_emax),
        .in_ops    (al_ops),
        .out_valid (out_valid),
        .result    (result)
    );

    // cycles since reset, saturating, for the latency check
    logic [CNT_W-1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)
            since_rst <= '0;
        else if (since_rst < CNT_W'(LATENCY))
            since_rst <= since_rst + 1'b1;
    end

    // R2: output strobe is the input strobe six cycles later
    p_latency_r2: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= CNT_W'(LATENCY)) |-> out_valid == $past(in_valid, LATENCY));
    // R2: nothing leaves before a set could have crossed the pipe
    p_quiet_start_r2: assert property (@(posedge clk) disable iff (rst)
        (since_rst < CNT_W'(LATENCY)) |-> !out_valid);

endmodule

// File: tb/fp3_adder_tb.sv
module fp3_adder_tb;

    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [31:0] op_c = '0;
    logic        out_valid;
    logic [31:0] result;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fp3_adder u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .op_a      (op_a),
        .op_b      (op_b),
        .op_c      (op_c),
        .out_valid (out_valid),
        .result    (result)
    );

    task automatic expect_word(input string req, input string what,
                               input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // expected sum computed from the requirements
    function automatic logic [31:0] ref_sum(input logic [31:0] a,
                                            input logic [31:0] b,
                                            input logic [31:0] c);
        logic [31:0] w [3];
        int          e [3];
        int          emax;
        int          d;
        int          p;
        int          ex;
        longint      m;
        longint      acc;
        longint      mag;
        logic        neg;
        w[0] = a; w[1] = b; w[2] = c;
        emax = 0;
        for (int i = 0; i < 3; i++) begin
            e[i] = int'(w[i][30:23]);
            if (e[i] > emax) emax = e[i];
        end
        acc = 0;
        for (int i = 0; i < 3; i++) begin
            if (e[i] != 0) begin
                m = longint'({1'b1, w[i][22:0]});
                d = emax - e[i];
                m = (d >= 24) ? 0 : (m >>> d);
                acc = w[i][31] ? acc - m : acc + m;
            end
        end
        if (acc == 0) return 32'h0;
        neg = (acc < 0);
        mag = neg ? -acc : acc;
        p = 0;
        for (int i = 0; i < 40; i++) if (((mag >>> i) & 1) != 0) p = i;
        ex = emax + p - 23;
        if (ex < 1) return 32'h0;
        mag = (p >= 23) ? (mag >>> (p - 23)) : (mag <<< (23 - p));
        return {neg, ex[7:0], mag[22:0]};
    endfunction

    // one operand set in isolation; checks silence before and the word at LAT
    task automatic run_one(input string req, input string what,
                           input logic [31:0] a, input logic [31:0] b,
                           input logic [31:0] c, input logic [31:0] exp);
        @(negedge clk);
        op_a = a; op_b = b; op_c = c; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (LAT - 2) @(negedge clk);
        expect_word("R2", {what, " early valid"}, {31'b0, out_valid}, 32'h0);
        @(negedge clk);
        expect_word("R2", {what, " valid"}, {31'b0, out_valid}, 32'h1);
        expect_word(req, what, result, exp);
    endtask

    task automatic t_reset;
        expect_word("R2", "reset valid", {31'b0, out_valid}, 32'h0);
        expect_word("R2", "reset result", result, 32'h0);
    endtask

    task automatic t_basic;
        run_one("R1", "1+2+3", 32'h3F800000, 32'h40000000, 32'h40400000, 32'h40C00000);
        run_one("R7", "carry 1.5x3", 32'h3FC00000, 32'h3FC00000, 32'h3FC00000, 32'h40900000);
        run_one("R7", "carry 1x3", 32'h3F800000, 32'h3F800000, 32'h3F800000, 32'h40400000);
    endtask

    task automatic t_zero_ops;
        run_one("R3", "denormal pattern ignored", 32'h00400000, 32'h3F800000, 32'h40000000, 32'h40400000);
        run_one("R3", "negative zero ignored", 32'h80000000, 32'h3F800000, 32'h00000000, 32'h3F800000);
        run_one("R3", "zero fraction all ones", 32'h807FFFFF, 32'h007FFFFF, 32'h40000000, 32'h40000000);
    endtask

    task automatic t_align;
        run_one("R4", "shift by 23", 32'h4B000000, 32'h3F800000, 32'h00000000, 32'h4B000001);
        run_one("R4", "2+0.5+0.25", 32'h40000000, 32'h3F000000, 32'h3E800000, 32'h40300000);
        run_one("R4", "shifted out bit lost", 32'h4B000000, 32'h3F000000, 32'h00000000, 32'h4B000000);
    endtask

    task automatic t_far;
        run_one("R5", "diff 30 dropped", 32'h4E800000, 32'h3F800000, 32'h3F800000, 32'h4E800000);
        run_one("R5", "diff 24 dropped", 32'h3F800000, 32'h4B800000, 32'h00000000, 32'h4B800000);
    endtask

    task automatic t_signed;
        run_one("R6", "1-3+0.5", 32'h3F800000, 32'hC0400000, 32'h3F000000, 32'hBFC00000);
        run_one("R6", "all negative", 32'hBF800000, 32'hBF800000, 32'hBF800000, 32'hC0400000);
    endtask

    task automatic t_norm;
        run_one("R7", "cancellation", 32'h3F800000, 32'hBF800000, 32'h3A800000, 32'h3A800000);
        run_one("R7", "truncation", 32'h3F800001, 32'h3F800001, 32'h3F800001, 32'h40400001);
    endtask

    task automatic t_exact_zero;
        run_one("R8", "-2+1+1", 32'hC0000000, 32'h3F800000, 32'h3F800000, 32'h00000000);
        run_one("R8", "all zero", 32'h00000000, 32'h00000000, 32'h00000000, 32'h00000000);
        run_one("R8", "all negative zero", 32'h80000000, 32'h80000000, 32'h80000000, 32'h00000000);
    endtask

    task automatic t_underflow;
        run_one("R9", "below exponent 1", 32'h00800000, 32'h80800001, 32'h00000000, 32'h00000000);
        run_one("R9", "exactly exponent 1", 32'h01000000, 32'h80800000, 32'h00000000, 32'h00800000);
    endtask

    function automatic logic [31:0] rand_op();
        if ($urandom_range(0, 7) == 0) return 32'h0;
        return {1'($urandom_range(0, 1)), 8'(100 + $urandom_range(0, 40)),
                23'($urandom())};
    endfunction

    // back-to-back sets, one per cycle
    task automatic t_stream;
        localparam int NV = 12;
        logic [31:0] va [NV];
        logic [31:0] vb [NV];
        logic [31:0] vc [NV];
        for (int i = 0; i < NV; i++) begin
            va[i] = rand_op(); vb[i] = rand_op(); vc[i] = rand_op();
        end
        for (int t = 0; t < NV + LAT; t++) begin
            @(negedge clk);
            if (t >= LAT) begin
                expect_word("R2", "stream valid", {31'b0, out_valid}, 32'h1);
                expect_word("R2", "stream result", result,
                            ref_sum(va[t-LAT], vb[t-LAT], vc[t-LAT]));
            end
            if (t < NV) begin
                op_a = va[t]; op_b = vb[t]; op_c = vc[t]; in_valid = 1'b1;
            end else begin
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        expect_word("R2", "stream drained", {31'b0, out_valid}, 32'h0);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 50000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_zero_ops();
        t_align();
        t_far();
        t_signed();
        t_norm();
        t_exact_zero();
        t_underflow();
        t_stream();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule